// File: doc/BRIEF.md
# Free-Running Period Meter with Overflow Extension

This block turns a pair of timer captures into a period measurement without ever disturbing the timer that produced them. A 16-bit timer runs freely outside the block, together with the logic that detects input edges. The block receives a one-cycle overflow pulse from that timer and a capture strobe carrying the 16-bit timer value latched at the edge. Captures alternate in role. The first capture of a pair opens a measurement window. The second capture closes it.

While the window is open, the block counts timer wraps in an 8-bit counter. When the window closes, it reports a 24-bit period: the wrap count sits above the wrapped 16-bit difference of the two captures. The count is corrected by one when that difference borrows. An overflow pulse that arrives in the same cycle as a capture is ordered by looking at the captured value. A captured value whose upper byte is zero means the timer had already wrapped when the edge was latched. A sticky flag records a window too long for the counter.

Top module: `period_meter_top`

## Requirements
- R1: After reset, `valid_o`, `period_o`, `armed_o` and `range_err_o` are all zero.
- R2: A capture while `armed_o` is 0 only stores its value. In the following cycle `armed_o` is 1 and `valid_o` stays 0.
- R3: A capture while `armed_o` is 1 completes a measurement. One cycle later `valid_o` is 1 and `period_o[15:0]` equals the second value minus the first value modulo 2^16.
- R4: `period_o[23:16]` equals the number of overflow pulses seen while `armed_o` was 1. Overflow pulses while `armed_o` is 0 are not counted.
- R5: If an overflow pulse and a capture arrive in the same cycle while `armed_o` is 1, the overflow is counted only when bits [15:8] of the captured value are 00h.
- R6: If the second value is below the first, the reported count is one less than the counted overflows. It does not go below zero.
- R7: A completed measurement clears the overflow count and drops `armed_o` to 0, so the next capture acts as a first capture.
- R8: The count saturates at 255. An overflow counted at 255 sets `range_err_o`, which stays 1 until reset.
- R9: `valid_o` is high for exactly one cycle per measurement. `period_o` keeps its value until the next completed measurement.
- R10: An overflow pulse that coincides with a first capture is never counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovf_i | input | 1 | One-cycle timer wrap pulse |
| cap_i | input | 1 | Capture strobe |
| cap_val_i | input | 16 | Timer value latched with the strobe |
| period_o | output | 24 | Overflow count over wrapped difference |
| valid_o | output | 1 | One-cycle result strobe |
| armed_o | output | 1 | 1 while waiting for a second capture |
| range_err_o | output | 1 | Sticky counter saturation flag |

## Verification
Every result of this block comes from a single register stage. `valid_o`, `period_o`, `armed_o` and `range_err_o` therefore reflect a capture or overflow pulse applied before a rising edge one cycle after that edge. The bench drives the strobes on the falling edge and samples all outputs shortly after the next rising edge. It updates its own model once per stimulus cycle and compares against the model at that single point. The model tracks window state, the first value, the wrap count and the error flag in plain integer arithmetic. The random phase mixes coincident overflow and capture pulses and captured values with a zero upper byte, so the ordering rule is exercised often.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef struct packed {
    logic inc;
    logic cap_first;
    logic cap_second;
  } pm_evt_t;
endpackage

// File: rtl/pm_arbiter.sv
module pm_arbiter #(
  parameter int HB = 8
) (
  input  logic            ovf,
  input  logic            cap,
  input  logic [HB-1:0]   cap_hi,
  input  logic            armed,
  output pm_pkg::pm_evt_t evt
);
  // A zero upper part in the captured value means the wrap came first.
  function automatic logic wrap_came_first(input logic [HB-1:0] hi);
    return hi == '0;
  endfunction

  always_comb begin
    evt.cap_first  = cap && !armed;
    evt.cap_second = cap && armed;
    evt.inc        = ovf && armed && (!cap || wrap_came_first(cap_hi));
  end
endmodule

// File: rtl/pm_ovf_count.sv
module pm_ovf_count #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          clr,
  input  logic          armed,
  output logic [CW-1:0] cnt_eff,
  output logic          err_o
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt_q;
  logic          err_q;
  logic          hit_max;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == CMAX) ? v : v + 1'b1;
  endfunction

  assign hit_max = inc && (cnt_q == CMAX);
  assign cnt_eff = inc ? sat_inc(cnt_q) : cnt_q;
  assign err_o   = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (clr)      cnt_q <= '0;
      else if (inc) cnt_q <= sat_inc(cnt_q);
      err_q <= err_q | hit_max;
    end
  end

  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> cnt_q == '0);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CMAX && !clr) |=> cnt_q == CMAX);
endmodule

// File: rtl/pm_result.sv
module pm_result #(
  parameter int TW = 16,
  parameter int CW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pm_pkg::pm_evt_t  evt,
  input  logic [TW-1:0]    cap_val,
  input  logic [CW-1:0]    cnt_eff,
  output logic             armed_o,
  output logic [TW+CW-1:0] period_o,
  output logic             valid_o
);
  localparam int PW = TW + CW;

  logic [TW-1:0] first_q;
  logic          armed_q;
  logic [PW-1:0] period_q;
  logic          valid_q;
  logic          borrow;

  function automatic logic [TW-1:0] wrap_diff(input logic [TW-1:0] b, input logic [TW-1:0] a);
    return b - a;
  endfunction

  function automatic logic [CW-1:0] dec_floor(input logic [CW-1:0] c, input logic br);
    return (br && c != '0) ? c - 1'b1 : c;
  endfunction

  assign borrow = cap_val < first_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q  <= '0;
      armed_q  <= 1'b0;
      period_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= evt.cap_second;
      if (evt.cap_first) begin
        first_q <= cap_val;
        armed_q <= 1'b1;
      end else if (evt.cap_second) begin
        armed_q  <= 1'b0;
        period_q <= {dec_floor(cnt_eff, borrow), wrap_diff(cap_val, first_q)};
      end
    end
  end

  assign armed_o  = armed_q;
  assign period_o = period_q;
  assign valid_o  = valid_q;

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  p_first_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt.cap_first |=> (!valid_q && armed_q));
  p_second_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt.cap_second |=> (valid_q && !armed_q));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !evt.cap_second |=> $stable(period_q));
endmodule

// File: rtl/period_meter_top.sv
module period_meter_top #(
  parameter int TW = 16,
  parameter int CW = 8,
  parameter int HB = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovf_i,
  input  logic             cap_i,
  input  logic [TW-1:0]    cap_val_i,
  output logic [TW+CW-1:0] period_o,
  output logic             valid_o,
  output logic             armed_o,
  output logic             range_err_o
);
  pm_pkg::pm_evt_t evt;
  logic [CW-1:0]   cnt_eff;
  logic            armed;

  pm_arbiter #(.HB(HB)) arb_i (
    .ovf    (ovf_i),
    .cap    (cap_i),
    .cap_hi (cap_val_i[TW-1 -: HB]),
    .armed  (armed),
    .evt    (evt)
  );

  pm_ovf_count #(.CW(CW)) cnt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (evt.inc),
    .clr     (evt.cap_second),
    .armed   (armed),
    .cnt_eff (cnt_eff),
    .err_o   (range_err_o)
  );

  pm_result #(.TW(TW), .CW(CW)) res_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .cap_val  (cap_val_i),
    .cnt_eff  (cnt_eff),
    .armed_o  (armed),
    .period_o (period_o),
    .valid_o  (valid_o)
  );

  assign armed_o = armed;

  p_no_count_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_o && ovf_i && cap_i) |=> (armed_o && !valid_o));
endmodule

// File: tb/period_meter_top_tb.sv
`timescale 1ns/1ps
module period_meter_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ovf_i = 1'b0;
  logic        cap_i = 1'b0;
  logic [15:0] cap_val_i = '0;
  logic [23:0] period_o;
  logic        valid_o, armed_o, range_err_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int m_armed = 0;
  int m_first = 0;
  int m_cnt = 0;
  int m_err = 0;
  int exp_period = 0;
  int exp_valid = 0;

  always #2 clk = ~clk;

  period_meter_top dut_i (
    .clk(clk), .rst_n(rst_n), .ovf_i(ovf_i), .cap_i(cap_i), .cap_val_i(cap_val_i),
    .period_o(period_o), .valid_o(valid_o), .armed_o(armed_o), .range_err_o(range_err_o)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic int diff16(input int b, input int a);
    return (b - a + 65536) % 65536;
  endfunction

  task automatic step(input bit ovf, input bit cap, input int val, input string tag);
    bit counted;
    @(negedge clk);
    ovf_i = ovf; cap_i = cap; cap_val_i = val[15:0];
    counted = (m_armed != 0) && ovf && (!cap || (val / 256) == 0);
    if (counted) begin
      if (m_cnt == 255) m_err = 1;
      else m_cnt++;
    end
    exp_valid = 0;
    if (cap) begin
      if (m_armed == 0) begin
        m_first = val; m_armed = 1;
      end else begin
        int up;
        up = m_cnt;
        if (val < m_first && up > 0) up--;
        exp_period = up * 65536 + diff16(val, m_first);
        exp_valid = 1; m_armed = 0; m_cnt = 0;
      end
    end
    @(posedge clk); #1;
    ovf_i = 0; cap_i = 0;
    chk(exp_valid ? "R3 valid" : "R9 valid", int'(valid_o), exp_valid);
    chk(exp_valid ? tag : "R9 hold", int'(period_o), exp_period);
    chk(cap ? "R2/R7 armed" : "R7 armed", int'(armed_o), m_armed);
    chk("R8 err", int'(range_err_o), m_err);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid", int'(valid_o), 0);
    chk("R1 period", int'(period_o), 0);
    chk("R1 armed", int'(armed_o), 0);
    chk("R1 err", int'(range_err_o), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2, R3 basic pair
    step(0, 1, 16'h1000, "R2");
    step(0, 1, 16'h1234, "R3");
    // R4: idle overflows ignored, armed overflows counted
    step(1, 0, 0, "R4"); step(1, 0, 0, "R4");
    step(0, 1, 16'h0100, "R4");
    step(1, 0, 0, "R4"); step(1, 0, 0, "R4");
    step(0, 1, 16'h0200, "R4");
    chk("R4 upper", int'(period_o[23:16]), 2);
    // R10: overflow with first capture not counted
    step(1, 1, 16'h0010, "R10");
    step(0, 1, 16'h0020, "R10");
    chk("R10 upper", int'(period_o[23:16]), 0);
    // R5: coincident overflow, upper byte zero -> counted
    step(0, 1, 16'h4000, "R5");
    step(1, 1, 16'h0012, "R5");
    chk("R5 counted", int'(period_o), 24'h00C012);
    // R5: coincident overflow, upper byte nonzero -> not counted
    step(0, 1, 16'h4000, "R5");
    step(1, 1, 16'h8000, "R5");
    chk("R5 not counted", int'(period_o), 24'h004000);
    // R6: borrow decrements
    step(0, 1, 16'hF000, "R6");
    step(1, 0, 0, "R6");
    step(0, 1, 16'h1000, "R6");
    chk("R6 borrow", int'(period_o), 24'h002000);
    // R6: floor at zero
    step(0, 1, 16'h9000, "R6");
    step(0, 1, 16'h1000, "R6");
    chk("R6 floor", int'(period_o), 24'h008000);
    // R7: next capture after result is a first capture
    step(0, 1, 16'h0005, "R7");
    chk("R7 rearm", int'(armed_o), 1);
    step(0, 1, 16'h0009, "R7");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      bit o, c;
      int v;
      o = ($urandom % 8) == 0;
      c = ($urandom % 6) == 0;
      v = $urandom % 65536;
      if (($urandom % 4) == 0) v = v % 256;
      step(o, c, v, "R3 rand");
    end

    // R8: saturation and sticky error
    if (m_armed != 0) step(0, 1, 16'h0000, "R8");
    step(0, 1, 16'h0100, "R8");
    for (int i = 0; i < 300; i++) step(1, 0, 0, "R8");
    step(0, 1, 16'h0300, "R8");
    chk("R8 sat", int'(period_o[23:16]), 255);
    chk("R8 flag", int'(range_err_o), 1);
    step(0, 1, 16'h0000, "R8");
    step(0, 1, 16'h0001, "R8");
    chk("R8 sticky", int'(range_err_o), 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule